// File: doc/BRIEF.md
# Hashed Page Table Group Walker

The walker turns an effective address into a physical page by searching a hashed page table held in memory. A request carries the effective address, the access kind (load, store or fetch), the privilege state, the segment word that applies to the address, and the table base and mask. From the segment identifier and the page index the block forms a hash and locates one group of eight two-word entries. It reads the entries one memory word per cycle until one matches. If the first group has no match, it repeats the scan in the group picked by the complemented hash.

When an entry matches, the block derives access rights from the entry's protection bits, the segment's key and no-execute bits and the privilege state, and grades the access as granted or a protection fault. It then maintains the referenced and changed bits of the entry's second word and writes that word back only if one of those bits changes. A search that finds nothing returns a miss and leaves memory untouched. Memory is a single synchronous port: read data arrives on the cycle after the enable.

Top module: `hpt_walker`

## Requirements
- R1: After reset and whenever no walk is in progress, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_en_o` is 0.
- R2: The page index is effective-address bits 27..12 and the segment identifier is segment-word bits 23..0. The first group address is base + (((identifier XOR index) << 6) AND mask). Entry k of a group has its first word at group + 8k and its second word at group + 8k + 4. An entry matches when first-word bit 31 (valid) is 1, bits 30..7 equal the identifier, bits 5..0 equal index bits 15..10, and bit 6 (hash select) equals the current phase.
- R3: The second group, at base + (((NOT hash) << 6) AND mask) with a 32-bit complement, is searched with phase 1, and only after all eight entries of the first group failed with phase 0.
- R4: Entries are scanned in ascending order within a group, and the first matching entry in that order is used.
- R5: The key is segment-word bit 30 when `req_user_i` is 1 and segment-word bit 31 when it is 0.
- R6: Protection value pp is second-word bits 1..0. With key 0, pp 3 gives read only and other values give read and write. With key 1, pp 0 gives nothing, pp 1 and 3 give read only, and pp 2 gives read and write. Execute is given unless segment-word bit 28 is 1. `rsp_perm_o` is {read, write, execute}, read in bit 2.
- R7: Access codes on `req_acc_i` are 0 for load, 1 for store and 2 for fetch. A load needs read, a store write and a fetch execute. `rsp_status_o` is 0 when granted and 2 for a protection fault. `rsp_page_o` is second-word bits 31..12 of the matching entry.
- R8: On a match the referenced bit (second-word bit 8) is set, and the changed bit (bit 7) is set for a granted store. The second word is written once to its own address, with other bits unchanged, only if one of these bits went from 0 to 1.
- R9: When the changed bit of the matched entry stays 0, the write right is cleared in `rsp_perm_o`. The access is still graded on the rights from R6.
- R10: When neither group matches, `rsp_status_o` is 1, `rsp_perm_o` and `rsp_page_o` are 0, and no memory write occurs.
- R11: A request is taken only while `req_ready_o` is 1. Each request gets exactly one single-cycle `rsp_valid_o` pulse, and request inputs seen during a walk are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken |
| req_ea_i | input | 32 | Effective address |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user_i | input | 1 | 1 for user state, 0 for supervisor |
| req_seg_i | input | 32 | Segment word: keys, no-execute, identifier |
| req_base_i | input | 32 | Table base byte address |
| req_mask_i | input | 32 | Table offset mask |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after enable |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 0 granted, 1 miss, 2 protection fault |
| rsp_page_o | output | 20 | Physical page number |
| rsp_perm_o | output | 3 | Rights {read, write, execute} |

## Verification
The bench places decoys in the first group: valid entries with the wrong select bit, the wrong index bits or the wrong identifier. A walker that ignores the select bit or checks only part of the compare field stops on a decoy and returns the wrong page. Matching entries placed only in the second group, one of them with select 0, catch a walker that skips the complemented hash or accepts phase-0 entries there. A sweep over privilege, both key bits, every protection value, no-execute and every access kind catches swapped keys, a wrong rights table, and a returned write right while the changed bit stays clear. Write-back is checked every cycle against the expected address and data, so a spurious store on a miss, on a repeat access, or with a lost referenced bit is reported.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W   = 32;
  localparam int VSID_W   = 24;
  localparam int PIDX_W   = 16;
  localparam int API_W    = 6;
  localparam int PAGE_W   = 20;

  // segment word fields
  localparam int SEG_KS   = 31;
  localparam int SEG_KU   = 30;
  localparam int SEG_NX   = 28;

  // entry first word
  localparam int W0_VALID = 31;
  localparam int W0_SEL   = 6;

  // entry second word
  localparam int W1_REF   = 8;
  localparam int W1_CHG   = 7;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] RSP_GRANT = 2'd0;
  localparam logic [1:0] RSP_MISS  = 2'd1;
  localparam logic [1:0] RSP_PROT  = 2'd2;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GROUP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [PIDX_W-1:0] pidx_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              phase_i,
  output logic [ADDR_W-1:0] group_o
);
  logic [ADDR_W-1:0] hash_pri, hash_sel, offset;

  always_comb begin
    hash_pri = ADDR_W'(vsid_i) ^ ADDR_W'(pidx_i);
    hash_sel = phase_i ? ~hash_pri : hash_pri;
    offset   = (hash_sel << GROUP_SHIFT) & mask_i;
    group_o  = base_i + offset;
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [API_W-1:0]  api_i,
  input  logic              phase_i,
  output logic              hit_o
);
  logic vsid_eq, api_eq;

  assign vsid_eq = (w0_i[W0_VALID-1 -: VSID_W] == vsid_i);
  assign api_eq  = (w0_i[API_W-1:0] == api_i);
  assign hit_o   = w0_i[W0_VALID] && (w0_i[W0_SEL] == phase_i) && vsid_eq && api_eq;
endmodule

// File: rtl/hpt_perm.sv
module hpt_perm
  import hpt_pkg::*;
(
  input  logic              user_i,
  input  logic              key_sup_i,
  input  logic              key_usr_i,
  input  logic              nx_i,
  input  logic [1:0]        acc_i,
  input  logic [WORD_W-1:0] w1_i,
  output rights_t           rights_o,
  output logic              ok_o,
  output logic [WORD_W-1:0] w1_new_o,
  output logic              wb_o
);
  logic    key;
  logic [1:0] pp;
  rights_t raw;
  logic    chg_new;

  assign key = user_i ? key_usr_i : key_sup_i;
  assign pp  = w1_i[1:0];

  always_comb begin
    raw.ex = ~nx_i;
    if (!key) begin
      raw.rd = 1'b1;
      raw.wr = (pp != 2'd3);
    end else begin
      raw.rd = (pp != 2'd0);
      raw.wr = (pp == 2'd2);
    end
  end

  always_comb begin
    unique case (acc_i)
      ACC_STORE: ok_o = raw.wr;
      ACC_FETCH: ok_o = raw.ex;
      default:   ok_o = raw.rd;
    endcase
  end

  always_comb begin
    chg_new          = w1_i[W1_CHG] | ((acc_i == ACC_STORE) & ok_o);
    w1_new_o         = w1_i;
    w1_new_o[W1_REF] = 1'b1;
    w1_new_o[W1_CHG] = chg_new;
    wb_o             = ~w1_i[W1_REF] | (chg_new & ~w1_i[W1_CHG]);
    rights_o         = raw;
    rights_o.wr      = raw.wr & chg_new;  // first store must fault in
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GROUP_ENTRIES = 8,
  parameter int ENTRY_BYTES   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_ea_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_user_i,
  input  logic [31:0]       req_seg_i,
  input  logic [31:0]       req_base_i,
  input  logic [31:0]       req_mask_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [19:0]       rsp_page_o,
  output logic [2:0]        rsp_perm_o
);
  localparam int IDX_W       = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
  localparam int GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
  localparam int ESHIFT      = $clog2(ENTRY_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);
  localparam logic [ADDR_W-1:0] W1_OFS  = ADDR_W'(WORD_W / 8);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_EVAL, S_WB, S_RESP} state_e;

  state_e             state_q;
  logic [VSID_W-1:0]  vsid_q;
  logic [PIDX_W-1:0]  pidx_q;
  logic               user_q, ks_q, ku_q, nx_q;
  logic [1:0]         acc_q;
  logic [ADDR_W-1:0]  base_q, mask_q;
  logic               phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  w0_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [1:0]         status_q;
  logic [PAGE_W-1:0]  page_q;
  logic [2:0]         perm_q;

  logic [ADDR_W-1:0]  group_addr, entry_addr;
  logic               hit, ok, wb;
  rights_t            rights;
  logic [WORD_W-1:0]  w1_new;

  logic unused_req_bits;
  assign unused_req_bits = ^{req_ea_i[31:28], req_ea_i[11:0], req_seg_i[29], req_seg_i[27:24]};

  hpt_hash #(.ADDR_W(ADDR_W), .GROUP_SHIFT(GROUP_SHIFT)) u_hash (
    .vsid_i (vsid_q),
    .pidx_i (pidx_q),
    .base_i (base_q),
    .mask_i (mask_q),
    .phase_i(phase_q),
    .group_o(group_addr)
  );

  assign entry_addr = group_addr + (ADDR_W'(idx_q) << ESHIFT);

  hpt_match u_match (
    .w0_i   (w0_q),
    .vsid_i (vsid_q),
    .api_i  (pidx_q[PIDX_W-1 -: API_W]),
    .phase_i(phase_q),
    .hit_o  (hit)
  );

  hpt_perm u_perm (
    .user_i   (user_q),
    .key_sup_i(ks_q),
    .key_usr_i(ku_q),
    .nx_i     (nx_q),
    .acc_i    (acc_q),
    .w1_i     (mem_rdata_i),
    .rights_o (rights),
    .ok_o     (ok),
    .w1_new_o (w1_new),
    .wb_o     (wb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      vsid_q   <= '0;
      pidx_q   <= '0;
      user_q   <= 1'b0;
      ks_q     <= 1'b0;
      ku_q     <= 1'b0;
      nx_q     <= 1'b0;
      acc_q    <= ACC_LOAD;
      base_q   <= '0;
      mask_q   <= '0;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      w0_q     <= '0;
      wdata_q  <= '0;
      status_q <= RSP_MISS;
      page_q   <= '0;
      perm_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          vsid_q  <= req_seg_i[VSID_W-1:0];
          pidx_q  <= req_ea_i[27:12];
          user_q  <= req_user_i;
          ks_q    <= req_seg_i[SEG_KS];
          ku_q    <= req_seg_i[SEG_KU];
          nx_q    <= req_seg_i[SEG_NX];
          acc_q   <= req_acc_i;
          base_q  <= ADDR_W'(req_base_i);
          mask_q  <= ADDR_W'(req_mask_i);
          phase_q <= 1'b0;
          idx_q   <= '0;
          state_q <= S_RD0;
        end
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          w0_q    <= mem_rdata_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (hit) begin
            status_q <= ok ? RSP_GRANT : RSP_PROT;
            page_q   <= mem_rdata_i[WORD_W-1 -: PAGE_W];
            perm_q   <= rights;
            wdata_q  <= w1_new;
            state_q  <= wb ? S_WB : S_RESP;
          end else if (idx_q == LAST_IDX) begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              idx_q   <= '0;
              state_q <= S_RD0;
            end else begin
              status_q <= RSP_MISS;
              page_q   <= '0;
              perm_q   <= '0;
              state_q  <= S_RESP;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RD0;
          end
        end
        S_WB:   state_q <= S_RESP;
        S_RESP: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD0: begin
        mem_en_o   = 1'b1;
        mem_addr_o = 32'(entry_addr);
      end
      S_RD1: begin
        mem_en_o   = 1'b1;
        mem_addr_o = 32'(entry_addr + W1_OFS);
      end
      S_WB: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = 32'(entry_addr + W1_OFS);
        mem_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o  = (state_q == S_IDLE);
  assign rsp_valid_o  = (state_q == S_RESP);
  assign rsp_status_o = status_q;
  assign rsp_page_o   = page_q;
  assign rsp_perm_o   = perm_q;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk
  import hpt_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [1:0]  req_acc_i,
  input logic        mem_en_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_status_o,
  input logic [2:0]  rsp_perm_o
);
  logic [1:0] acc_q;
  logic       wrote_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= ACC_LOAD;
      wrote_q <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      acc_q   <= req_acc_i;
      wrote_q <= 1'b0;
    end else if (mem_we_o) begin
      wrote_q <= 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_en_o && !rsp_valid_o));

  assert_wb_word1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_en_o && mem_addr_o[2:0] == 3'd4 && mem_wdata_o[W1_REF]));

  assert_single_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_rsp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_miss_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_MISS) |-> (!wrote_q && rsp_perm_o == 3'b000));

  assert_grant_rights_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RSP_GRANT) |->
      ((acc_q == ACC_STORE) ? rsp_perm_o[1] :
       (acc_q == ACC_FETCH) ? rsp_perm_o[0] : rsp_perm_o[2]));
endmodule

bind hpt_walker hpt_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_acc_i   (req_acc_i),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .rsp_perm_o  (rsp_perm_o)
);

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_ea = 0;
  logic [1:0]  req_acc = 0;
  logic        req_user = 0;
  logic [31:0] req_seg = 0;
  logic [31:0] req_base = 0;
  logic [31:0] req_mask = 0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [19:0] rsp_page;
  logic [2:0]  rsp_perm;

  always #5 clk = ~clk;

  hpt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ea_i(req_ea), .req_acc_i(req_acc), .req_user_i(req_user),
    .req_seg_i(req_seg), .req_base_i(req_base), .req_mask_i(req_mask),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status),
    .rsp_page_o(rsp_page), .rsp_perm_o(rsp_perm)
  );

  int unsigned mem [int unsigned];
  int compared = 0, mismatched = 0;
  int cycles = 0;
  int wb_seen = 0, rsp_seen = 0;
  bit exp_wb = 0;
  int unsigned exp_wb_addr = 0, exp_wb_data = 0;
  int unsigned base_g = 32'h0010_0000, mask_g = 32'h000F_FFC0;

  function automatic int unsigned rd(int unsigned a);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= rd(mem_addr);
    end
  end

  task automatic check(string tag, int unsigned act, int unsigned exp_v);
    compared++;
    if (act != exp_v) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // per-clock observation of writes and responses
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (mem_we) begin
        wb_seen++;
        check("R8 write address", mem_addr, exp_wb ? exp_wb_addr : 32'hFFFF_FFFF);
        check("R8 write data", mem_wdata, exp_wb ? exp_wb_data : 32'hFFFF_FFFF);
      end
      if (rsp_valid) rsp_seen++;
    end
  end

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic int unsigned grp(int unsigned seg, int unsigned ea, int ph);
    int unsigned h;
    h = (seg & 32'h00FF_FFFF) ^ ((ea >> 12) & 32'hFFFF);
    if (ph != 0) h = ~h;
    return base_g + ((h << 6) & mask_g);
  endfunction

  function automatic int unsigned mk_w0(int unsigned seg, int unsigned ea, int sel);
    return 32'h8000_0000 | ((seg & 32'h00FF_FFFF) << 7) | (sel << 6) | ((ea >> 22) & 32'h3F);
  endfunction

  function automatic int unsigned mk_w1(int unsigned rpn, int r, int c, int pp);
    return (rpn << 12) | (r << 8) | (c << 7) | (pp & 3);
  endfunction

  // behavioural reference of the whole walk
  task automatic model(input int unsigned ea, input int acc, input int user, input int unsigned seg,
                       output int st, output int unsigned page, output int perm,
                       output bit wb, output int unsigned wa, output int unsigned wd);
    bit found = 0;
    int unsigned a = 0, w1;
    int key, pp;
    bit r, w, x, okk, c_new;
    for (int ph = 0; ph < 2 && !found; ph++)
      for (int e = 0; e < 8 && !found; e++) begin
        int unsigned w0;
        a  = grp(seg, ea, ph) + e * 8;
        w0 = rd(a);
        if (w0[31] && w0[6] == ph[0] && w0[30:7] == seg[23:0] && w0[5:0] == ea[27:22]) found = 1;
      end
    wb = 0; wa = 0; wd = 0;
    if (!found) begin st = 1; page = 0; perm = 0; return; end
    w1  = rd(a + 4);
    key = user ? seg[30] : seg[31];
    pp  = w1 & 3;
    case ({key[0], pp[1:0]})
      3'b000, 3'b001, 3'b010: begin r = 1; w = 1; end
      3'b011:                 begin r = 1; w = 0; end
      3'b100:                 begin r = 0; w = 0; end
      3'b110:                 begin r = 1; w = 1; end
      default:                begin r = 1; w = 0; end
    endcase
    x   = !seg[28];
    okk = (acc == 1) ? w : (acc == 2) ? x : r;
    st  = okk ? 0 : 2;
    page = w1 >> 12;
    c_new = w1[7] || (acc == 1 && okk);
    perm = {r, w && c_new, x};
    if (!w1[8] || (c_new && !w1[7])) begin
      wb = 1; wa = a + 4;
      wd = w1 | 32'h100 | (c_new ? 32'h80 : 0);
    end
  endtask

  task automatic run(string tag, int unsigned ea, int acc, int user, int unsigned seg,
                     int hold_extra = 0);
    int st, perm;
    int unsigned page, wa, wd;
    bit wb;
    int wb0, rsp0, guard;
    model(ea, acc, user, seg, st, page, perm, wb, wa, wd);
    exp_wb = wb; exp_wb_addr = wa; exp_wb_data = wd;
    while (!req_ready) @(negedge clk);
    wb0 = wb_seen; rsp0 = rsp_seen;
    req_valid = 1; req_ea = ea; req_acc = acc[1:0]; req_user = user[0];
    req_seg = seg; req_base = base_g; req_mask = mask_g;
    @(negedge clk);
    if (hold_extra != 0) begin
      // R11: altered fields during the walk must be ignored
      req_ea = ea ^ 32'h0550_0000; req_acc = 2'd1; req_seg = seg ^ 32'hC000_0001;
      repeat (hold_extra) @(negedge clk);
    end
    req_valid = 0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    check({tag, " status"}, rsp_status, st);
    check({tag, " page"}, rsp_page, page);
    check({tag, " perm"}, rsp_perm, perm);
    @(negedge clk);
    @(negedge clk);
    check({tag, " R8 write count"}, wb_seen - wb0, wb ? 1 : 0);
    check({tag, " R11 response count"}, rsp_seen - rsp0, 1);
    if (wb) check({tag, " R8 memory word"}, rd(wa), wd);
  endtask

  initial begin
    int unsigned seg, ea, g;
    seg = 32'h0000_1234;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 no response after reset", rsp_valid, 0);
    check("R1 memory idle after reset", mem_en, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready idle", req_ready, 1);

    // R2/R9: first entry of primary group, load, write right dropped
    ea = 32'h0ABC_D123;
    mem[grp(seg, ea, 0)]     = mk_w0(seg, ea, 0);
    mem[grp(seg, ea, 0) + 4] = mk_w1(20'h5A5A5, 0, 0, 2);
    run("R2 R9 primary hit", ea, 0, 0, seg);
    check("R9 no write right", rsp_perm[1], 0);

    // R2/R4: decoys then two matches, first wins
    ea = 32'h0123_4000; g = grp(seg, ea, 0);
    mem[g]      = mk_w0(seg, ea, 1);               mem[g + 4]  = mk_w1(1, 0, 0, 2);
    mem[g + 8]  = mk_w0(seg, ea, 0) ^ 32'h1;       mem[g + 12] = mk_w1(2, 0, 0, 2);
    mem[g + 16] = mk_w0(seg, ea, 0) ^ 32'h100;     mem[g + 20] = mk_w1(3, 0, 0, 2);
    mem[g + 24] = mk_w0(seg, ea, 0) & 32'h7FFF_FFFF; mem[g + 28] = mk_w1(4, 0, 0, 2);
    mem[g + 40] = mk_w0(seg, ea, 0);               mem[g + 44] = mk_w1(20'hABCDE, 1, 0, 3);
    mem[g + 48] = mk_w0(seg, ea, 0);               mem[g + 52] = mk_w1(20'h11111, 0, 0, 2);
    run("R4 first match", ea, 0, 0, seg);
    check("R4 page of entry 5", rsp_page, 20'hABCDE);

    // R3: secondary group only, select-0 copy there skipped
    ea = 32'h0777_7000; g = grp(seg, ea, 1);
    mem[grp(seg, ea, 0) + 16] = mk_w0(seg, ea, 1);
    mem[grp(seg, ea, 0) + 20] = mk_w1(20'h22222, 0, 0, 2);
    mem[g + 16] = mk_w0(seg, ea, 0);   mem[g + 20] = mk_w1(20'h33333, 0, 0, 2);
    mem[g + 48] = mk_w0(seg, ea, 1);   mem[g + 52] = mk_w1(20'h44444, 0, 1, 2);
    run("R3 secondary hit", ea, 1, 0, seg);
    check("R3 page from secondary", rsp_page, 20'h44444);

    // R10: miss in both groups
    run("R10 miss", 32'h0FED_C000, 0, 0, seg);
    check("R10 status miss", rsp_status, 1);

    // R8: granted store sets C; repeat load writes nothing
    ea = 32'h0246_8000; g = grp(seg, ea, 0);
    mem[g + 8] = mk_w0(seg, ea, 0); mem[g + 12] = mk_w1(20'h0F0F0, 1, 0, 2);
    run("R8 store sets changed", ea, 1, 0, seg);
    run("R8 repeat no write", ea, 0, 0, seg);

    // R11: request fields held and altered during walk
    run("R11 busy ignore", ea, 0, 0, seg, 3);

    // R5/R6/R7: full sweep of keys, privilege, pp, nx, access
    ea = 32'h0135_7000;
    for (int ks = 0; ks < 2; ks++)
      for (int ku = 0; ku < 2; ku++)
        for (int nx = 0; nx < 2; nx++)
          for (int u = 0; u < 2; u++)
            for (int pp = 0; pp < 4; pp++)
              for (int acc = 0; acc < 3; acc++) begin
                int unsigned s;
                s = (ks << 31) | (ku << 30) | (nx << 28) | 32'h0000_0ACE;
                g = grp(s, ea, 0);
                mem[g]     = mk_w0(s, ea, 0);
                mem[g + 4] = mk_w1(20'h76543, 0, 0, pp);
                run("R5 R6 R7 sweep", ea, acc, u, s);
              end

    // R2: different base and mask
    base_g = 32'h0020_0000; mask_g = 32'h0000_3FC0;
    ea = 32'h0FFF_F000; g = grp(seg, ea, 0);
    mem[g + 56] = mk_w0(seg, ea, 0); mem[g + 60] = mk_w1(20'h9999A, 1, 1, 0);
    run("R2 masked table", ea, 2, 1, seg);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule